// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter with Priority Rejection

This block sits between one processor and the source controllers of an interrupt fabric. It holds the processor's current priority, the priority of a software inter-processor interrupt request, one pending slot (a 24-bit source identifier with its priority) and a flag that records a missed delivery. Lower numbers are more favoured, and 0xFF means masked. A source controller offers an interrupt at a given priority. The block either takes the offer or marks that a resend is owed. When it takes an offer, a less favoured source that was already pending is displaced and handed back as a reject.

The processor side has four operations: accept, change priority, set the inter-processor priority, and end-of-interrupt. The block applies one operation per cycle on a single command port, and each operation is atomic. Results come back the following cycle: the accepted word, rejects, resend requests and end-of-interrupt acknowledges. The inter-processor interrupt shares the pending slot under the reserved identifier 2. A reject or acknowledge for that identifier, and a reject for the empty identifier 0, is never forwarded. The interrupt line to the processor is derived from the registered state.

Top module: `int_presenter`

## Requirements
- R1: An offer (op_code 1, op_data[31:24] = priority p, op_data[23:0] = identifier) is taken only when p is strictly less than the current priority, the inter-processor priority and the pending priority. A taken offer installs its identifier and priority in the pending slot and pulses offer_taken.
- R2: An offer that is not taken sets the need-resend flag. The flag is observed as a later resend_req pulse.
- R3: irq_out is high exactly when the pending identifier is nonzero and the pending priority is numerically below the current priority.
- R4: Accept (op_code 2) pulses acc_valid with acc_word = {current priority, pending identifier}. It then sets the current priority to the old pending priority, the pending priority to 0xFF and the identifier to 0.
- R5: Set priority (op_code 3, new value in op_data[31:24]) with a value below the current priority stores it. If the value is also at or below the pending priority, the pending identifier is rejected and the slot empties to 0xFF. An equal value changes nothing.
- R6: Set priority with a value above the current priority stores it. If the inter-processor priority is below the new value and at or below the pending priority, identifier 2 becomes pending at the inter-processor priority. The need-resend flag is then output on resend_req and cleared.
- R7: Set inter-processor priority (op_code 4, value m in op_data[31:24]) stores m. If m is below the current priority and at or below the pending priority, the pending identifier is rejected and identifier 2 is installed at m. If m is above the old value, the need-resend flag is output on resend_req and cleared.
- R8: End-of-interrupt (op_code 5) applies op_data[31:24] as a priority decrease, as in R6. It pulses ack_valid with ack_id = op_data[23:0], except when that identifier is 2.
- R9: A displaced identifier is output on rej_valid/rej_id only when it is neither 0 nor 2.
- R10: After reset the current priority is 0, the inter-processor and pending priorities are 0xFF, the identifier is 0 and irq_out is low.
- R11: Every result pulse appears in the cycle after the operation's clock edge and only for that operation. Op_code 0 or a low op_valid produces no result and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | 0 none, 1 offer, 2 accept, 3 set priority, 4 set inter-processor priority, 5 end-of-interrupt |
| op_data | input | 32 | Priority in bits 31:24, identifier in bits 23:0 |
| irq_out | output | 1 | Interrupt request to the processor |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 32 | Current priority and pending identifier at the time of accept |
| offer_taken | output | 1 | The last offer was taken |
| rej_valid | output | 1 | A displaced source must be offered again |
| rej_id | output | 24 | Identifier of the displaced source |
| resend_req | output | 1 | Source controllers should resend missed offers |
| ack_valid | output | 1 | End-of-interrupt acknowledge to the source controller |
| ack_id | output | 24 | Identifier being acknowledged |

## Verification
All result pulses and acc_word are registered. Each one is valid for exactly the one cycle after the clock edge that applies the operation. irq_out is decoded from the registered state, so it also settles by that cycle. The bench drives each operation on a falling edge and lets one rising edge pass. It samples every output on the next falling edge, and only then presents the following operation. This keeps each observation tied to a single operation and away from the active edge.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_OFFER  = 3'd1,
    OP_ACCEPT = 3'd2,
    OP_SETPRI = 3'd3,
    OP_SETIPI = 3'd4,
    OP_EOI    = 3'd5
  } ipres_op_e;
endpackage

// File: rtl/ipres_offer_eval.sv
module ipres_offer_eval #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] cur_prio,
  input  logic [PW-1:0] ipi_prio,
  input  logic [PW-1:0] pend_prio,
  input  logic [PW-1:0] offer_prio,
  output logic          take
);
  // strictly more favoured than all three holders
  always_comb begin
    take = (offer_prio < cur_prio) && (offer_prio < ipi_prio) &&
           (offer_prio < pend_prio);
  end
endmodule

// File: rtl/ipres_fwd_filter.sv
module ipres_fwd_filter #(
  parameter int          IW        = 24,
  parameter logic [IW-1:0] IPI_ID  = 2,
  parameter bit          DROP_ZERO = 1'b1
) (
  input  logic          vld_in,
  input  logic [IW-1:0] id_in,
  output logic          vld_out,
  output logic [IW-1:0] id_out
);
  logic keep;
  generate
    if (DROP_ZERO) begin : g_drop_zero
      always_comb keep = (id_in != '0) && (id_in != IPI_ID);
    end else begin : g_keep_zero
      always_comb keep = (id_in != IPI_ID);
    end
  endgenerate

  always_comb begin
    vld_out = vld_in && keep;
    id_out  = keep ? id_in : '0;
  end
endmodule

// File: rtl/ipres_next.sv
module ipres_next
  import ipres_pkg::*;
#(
  parameter int          PW     = 8,
  parameter int          IW     = 24,
  parameter logic [IW-1:0] IPI_ID = 2
) (
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [PW-1:0] op_prio,
  input  logic [IW-1:0] op_id,
  input  logic [PW-1:0] cur_q,
  input  logic [PW-1:0] ipi_q,
  input  logic [PW-1:0] pp_q,
  input  logic [IW-1:0] pid_q,
  input  logic          nr_q,
  output logic [PW-1:0] cur_d,
  output logic [PW-1:0] ipi_d,
  output logic [PW-1:0] pp_d,
  output logic [IW-1:0] pid_d,
  output logic          nr_d,
  output logic          acc_v,
  output logic [PW+IW-1:0] acc_w,
  output logic          taken,
  output logic          rej_v,
  output logic [IW-1:0] rej_id,
  output logic          resend,
  output logic          ack_v,
  output logic [IW-1:0] ack_id
);
  localparam logic [PW-1:0] MASKED = '1;

  logic take;
  logic down;

  ipres_offer_eval #(.PW(PW)) u_eval (
    .cur_prio  (cur_q),
    .ipi_prio  (ipi_q),
    .pend_prio (pp_q),
    .offer_prio(op_prio),
    .take      (take)
  );

  always_comb begin
    cur_d  = cur_q;
    ipi_d  = ipi_q;
    pp_d   = pp_q;
    pid_d  = pid_q;
    nr_d   = nr_q;
    acc_v  = 1'b0;
    acc_w  = '0;
    taken  = 1'b0;
    rej_v  = 1'b0;
    rej_id = '0;
    resend = 1'b0;
    ack_v  = 1'b0;
    ack_id = '0;
    down   = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_OFFER: begin
          if (take) begin
            taken  = 1'b1;
            rej_v  = 1'b1;
            rej_id = pid_q;
            pid_d  = op_id;
            pp_d   = op_prio;
          end else begin
            nr_d = 1'b1;
          end
        end
        OP_ACCEPT: begin
          acc_v = 1'b1;
          acc_w = {cur_q, pid_q};
          cur_d = pp_q;
          pp_d  = MASKED;
          pid_d = '0;
        end
        OP_SETPRI: begin
          if (op_prio > cur_q) begin
            down = 1'b1;
          end else if (op_prio < cur_q) begin
            cur_d = op_prio;
            if (op_prio <= pp_q) begin
              rej_v  = 1'b1;
              rej_id = pid_q;
              pid_d  = '0;
              pp_d   = MASKED;
            end
          end
        end
        OP_SETIPI: begin
          ipi_d = op_prio;
          if ((op_prio < cur_q) && (op_prio <= pp_q)) begin
            rej_v  = 1'b1;
            rej_id = pid_q;
            pp_d   = op_prio;
            pid_d  = IPI_ID;
          end
          if (op_prio > ipi_q) begin
            resend = nr_q;
            nr_d   = 1'b0;
          end
        end
        OP_EOI: begin
          down   = 1'b1;
          ack_v  = 1'b1;
          ack_id = op_id;
        end
        default: ;
      endcase
    end
    // shared priority-decrease path
    if (down) begin
      cur_d = op_prio;
      if ((ipi_q < op_prio) && (ipi_q <= pp_q)) begin
        pp_d  = ipi_q;
        pid_d = IPI_ID;
      end
      resend = nr_q;
      nr_d   = 1'b0;
    end
  end
endmodule

// File: rtl/int_presenter.sv
module int_presenter
  import ipres_pkg::*;
#(
  parameter int PW     = 8,
  parameter int IW     = 24,
  parameter int IPI_ID = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [PW+IW-1:0] op_data,
  output logic             irq_out,
  output logic             acc_valid,
  output logic [PW+IW-1:0] acc_word,
  output logic             offer_taken,
  output logic             rej_valid,
  output logic [IW-1:0]    rej_id,
  output logic             resend_req,
  output logic             ack_valid,
  output logic [IW-1:0]    ack_id
);
  localparam int            WW       = PW + IW;
  localparam logic [PW-1:0] MASKED   = '1;
  localparam logic [IW-1:0] IPI_CODE = IW'(IPI_ID);

  // reset synchroniser: asserts at once, releases on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  logic [PW-1:0] op_prio;
  logic [IW-1:0] op_id;
  assign op_prio = op_data[WW-1:IW];
  assign op_id   = op_data[IW-1:0];

  logic [PW-1:0] cur_q, ipi_q, pp_q, cur_d, ipi_d, pp_d;
  logic [IW-1:0] pid_q, pid_d;
  logic          nr_q, nr_d;
  logic          acc_v, taken, rej_raw_v, resend, ack_raw_v;
  logic [WW-1:0] acc_w;
  logic [IW-1:0] rej_raw_id, ack_raw_id;
  logic          rej_f_v, ack_f_v;
  logic [IW-1:0] rej_f_id, ack_f_id;
  logic          st_en;

  ipres_next #(.PW(PW), .IW(IW), .IPI_ID(IPI_CODE)) u_next (
    .op_valid(op_valid), .op_code(op_code), .op_prio(op_prio), .op_id(op_id),
    .cur_q(cur_q), .ipi_q(ipi_q), .pp_q(pp_q), .pid_q(pid_q), .nr_q(nr_q),
    .cur_d(cur_d), .ipi_d(ipi_d), .pp_d(pp_d), .pid_d(pid_d), .nr_d(nr_d),
    .acc_v(acc_v), .acc_w(acc_w), .taken(taken),
    .rej_v(rej_raw_v), .rej_id(rej_raw_id), .resend(resend),
    .ack_v(ack_raw_v), .ack_id(ack_raw_id)
  );

  ipres_fwd_filter #(.IW(IW), .IPI_ID(IPI_CODE), .DROP_ZERO(1'b1)) u_rej_flt (
    .vld_in(rej_raw_v), .id_in(rej_raw_id), .vld_out(rej_f_v), .id_out(rej_f_id)
  );

  ipres_fwd_filter #(.IW(IW), .IPI_ID(IPI_CODE), .DROP_ZERO(1'b0)) u_ack_flt (
    .vld_in(ack_raw_v), .id_in(ack_raw_id), .vld_out(ack_f_v), .id_out(ack_f_id)
  );

  assign st_en = op_valid;

  // presenter state, enabled only by an operation
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cur_q <= '0;
      ipi_q <= MASKED;
      pp_q  <= MASKED;
      pid_q <= '0;
      nr_q  <= 1'b0;
    end else if (st_en) begin
      cur_q <= cur_d;
      ipi_q <= ipi_d;
      pp_q  <= pp_d;
      pid_q <= pid_d;
      nr_q  <= nr_d;
    end
  end

  // one-cycle result registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      acc_valid   <= 1'b0;
      acc_word    <= '0;
      offer_taken <= 1'b0;
      rej_valid   <= 1'b0;
      rej_id      <= '0;
      resend_req  <= 1'b0;
      ack_valid   <= 1'b0;
      ack_id      <= '0;
    end else begin
      acc_valid   <= acc_v;
      acc_word    <= acc_w;
      offer_taken <= taken;
      rej_valid   <= rej_f_v;
      rej_id      <= rej_f_id;
      resend_req  <= resend;
      ack_valid   <= ack_f_v;
      ack_id      <= ack_f_id;
    end
  end

  assign irq_out = (pid_q != '0) && (pp_q < cur_q);

  // R1: a taken offer leaves its own priority in the slot
  assert_taken_prio_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    offer_taken |-> (pp_q == $past(op_prio)));

  // R2: an offer either lands or leaves the resend flag set
  assert_miss_flag_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_OFFER) |=> (offer_taken || nr_q));

  // R4: nothing is presented straight after an accept
  assert_accept_quiet_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_ACCEPT) |=> !irq_out);

  // R5: raising priority over the pending one empties the slot
  assert_raise_empties_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == OP_SETPRI && op_prio < cur_q && op_prio <= pp_q)
      |=> (pid_q == '0 && pp_q == MASKED));

  // R6: a resend request only follows a priority-lowering operation
  assert_resend_source_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    resend_req |-> $past(op_valid && (op_code == OP_SETPRI ||
                                      op_code == OP_SETIPI || op_code == OP_EOI)));

  // R11: results appear only for an operation
  assert_result_needs_op_R11: assert property (@(posedge clk) disable iff (!rst_ok)
    (rej_valid || acc_valid || ack_valid) |-> $past(op_valid));
endmodule

// File: tb/int_presenter_test.sv
`timescale 1ns/100ps
module int_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] op_data;
  logic        irq_out, acc_valid, offer_taken, rej_valid, resend_req, ack_valid;
  logic [31:0] acc_word;
  logic [23:0] rej_id, ack_id;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  int_presenter uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .irq_out(irq_out), .acc_valid(acc_valid),
    .acc_word(acc_word), .offer_taken(offer_taken), .rej_valid(rej_valid),
    .rej_id(rej_id), .resend_req(resend_req), .ack_valid(ack_valid),
    .ack_id(ack_id)
  );

  // op, data, irq, taken, rej_v, rej_id, resend, acc_word, ack_v, ack_id
  localparam int NV = 15;
  localparam logic [119:0] VEC [NV] = '{
    {3'd1, 32'h05000100, 1'b0, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd3, 32'h10000000, 1'b0, 1'b0, 1'b0, 24'h0,   1'b1, 32'h0,        1'b0, 24'h0},
    {3'd1, 32'h08000100, 1'b1, 1'b1, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd1, 32'h03000200, 1'b1, 1'b1, 1'b1, 24'h100, 1'b0, 32'h0,        1'b0, 24'h0},
    {3'd1, 32'h03000300, 1'b1, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd2, 32'h00000000, 1'b0, 1'b0, 1'b0, 24'h0,   1'b0, 32'h10000200, 1'b0, 24'h0},
    {3'd4, 32'h01000000, 1'b1, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd1, 32'h00000400, 1'b1, 1'b1, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd3, 32'h00000000, 1'b0, 1'b0, 1'b1, 24'h400, 1'b0, 32'h0,        1'b0, 24'h0},
    {3'd4, 32'h20000000, 1'b0, 1'b0, 1'b0, 24'h0,   1'b1, 32'h0,        1'b0, 24'h0},
    {3'd5, 32'h40000400, 1'b1, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b1, 24'h400},
    {3'd2, 32'h00000000, 1'b0, 1'b0, 1'b0, 24'h0,   1'b0, 32'h40000002, 1'b0, 24'h0},
    {3'd5, 32'hFF000002, 1'b1, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd4, 32'hFF000000, 1'b1, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0},
    {3'd3, 32'h10000000, 1'b0, 1'b0, 1'b0, 24'h0,   1'b0, 32'h0,        1'b0, 24'h0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called on a falling edge; returns on the falling edge after the op edge
  task automatic run_op(input logic [2:0] code, input logic [31:0] data);
    op_valid = 1'b1;
    op_code  = code;
    op_data  = data;
    @(posedge clk);
    #1 op_valid = 1'b0;
    op_code = 3'd0;
    op_data = 32'h0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    op_valid = 1'b0;
    op_code  = 3'd0;
    op_data  = 32'h0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic no_pulses(input string req);
    chk(req, "acc_valid", 32'(acc_valid), 0);
    chk(req, "rej_valid", 32'(rej_valid), 0);
    chk(req, "resend_req", 32'(resend_req), 0);
    chk(req, "ack_valid", 32'(ack_valid), 0);
    chk(req, "offer_taken", 32'(offer_taken), 0);
  endtask

  initial begin
    #(5 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R10: quiet outputs after reset
    chk("R10", "irq_out", 32'(irq_out), 0);
    no_pulses("R10");
    // R10: current priority 0, empty slot
    run_op(3'd2, 32'h0);
    chk("R10", "acc_word", acc_word, 32'h00000000);
    do_reset();
    // R10: inter-processor and pending priorities start at 0xFF
    run_op(3'd3, 32'hFF000000);
    chk("R10", "irq_out", 32'(irq_out), 0);
    run_op(3'd1, 32'hFE000010);
    chk("R10", "offer_taken", 32'(offer_taken), 1);
    chk("R3", "irq_out", 32'(irq_out), 1);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [119:0] v;
      v = VEC[i];
      run_op(v[119:117], v[116:85]);
      chk("R3", $sformatf("irq_out v%0d", i), 32'(irq_out), 32'(v[84]));
      chk("R1", $sformatf("offer_taken v%0d", i), 32'(offer_taken), 32'(v[83]));
      chk("R9", $sformatf("rej_valid v%0d", i), 32'(rej_valid), 32'(v[82]));
      if (v[82]) chk("R5", $sformatf("rej_id v%0d", i), 32'(rej_id), 32'(v[81:58]));
      chk("R6", $sformatf("resend_req v%0d", i), 32'(resend_req), 32'(v[57]));
      chk("R11", $sformatf("acc_valid v%0d", i), 32'(acc_valid),
          32'(v[119:117] == 3'd2));
      if (v[119:117] == 3'd2) chk("R4", $sformatf("acc_word v%0d", i), acc_word, v[56:25]);
      chk("R8", $sformatf("ack_valid v%0d", i), 32'(ack_valid), 32'(v[24]));
      if (v[24]) chk("R8", $sformatf("ack_id v%0d", i), 32'(ack_id), 32'(v[23:0]));
    end
    // table covers R2 (v0 miss then v1 resend), R7 (v6, v9, v13)

    // R5: same priority again changes nothing
    run_op(3'd1, 32'h05000500);
    chk("R1", "offer_taken", 32'(offer_taken), 1);
    run_op(3'd3, 32'h10000000);
    chk("R5", "rej_valid", 32'(rej_valid), 0);
    chk("R5", "irq_out", 32'(irq_out), 1);
    // R11: idle cycle and a NOP opcode produce nothing
    run_op(3'd0, 32'h01000000);
    no_pulses("R11");
    chk("R11", "irq_out", 32'(irq_out), 1);
    run_op(3'd2, 32'h0);
    chk("R11", "acc_word", acc_word, 32'h10000500);
    // R10: reset in the middle of activity
    do_reset();
    chk("R10", "irq_out", 32'(irq_out), 0);
    no_pulses("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule